// File: doc/BRIEF.md
# SPI FIFO Interrupt and Status Unit

This unit sits beside the transmit and receive FIFOs of a serial peripheral controller. It watches the fill levels and the push and pop requests, and from them it forms a five-bit status word and a five-bit raw interrupt word. Two interrupt sources follow the FIFO levels against programmable thresholds and clear themselves. The other three record error events: a push into a full transmit FIFO, a push into a full receive FIFO, and a pop from an empty receive FIFO. These three stay set until software clears them.

The unit also gates the FIFO strobes. A request that would overflow or underflow a FIFO is refused, so the word is dropped. While the controller is disabled, the unit asks the FIFOs to flush and refuses every request. A five-bit mask selects which raw interrupts reach the masked word, and the interrupt line is the OR of that masked word. Software clears the sticky events by writing ones to a four-bit clear register.

Top module: `spi_irq_status`

## Requirements
- R1: One clock edge after the levels are sampled, statusWord reports transmit full at bit 1 (level equals FIFO_DEPTH), transmit empty at bit 2 (level zero), receive empty at bit 3 and receive full at bit 4.
- R2: statusWord bit 0 (busy) is set one edge after ctrlEnable is high and either engineBusy is high or the transmit level is nonzero. It is clear otherwise.
- R3: rawInt bit 0 is set one edge after the transmit level is less than or equal to txThresh, and is clear otherwise. It follows the level with no clear needed.
- R4: rawInt bit 4 is set one edge after the receive level is strictly greater than rxThresh, and is clear otherwise.
- R5: While enabled, a transmit push request at a full level is refused (txPushOk low) and sets rawInt bit 1, which stays set until cleared. A request below full is accepted.
- R6: While enabled, a receive pop request at level zero is refused (rxPopOk low) and sets rawInt bit 2, which stays set until cleared.
- R7: While enabled, a receive push request at a full level is refused (rxPushOk low) and sets rawInt bit 3, which stays set until cleared.
- R8: A write with clrWrite high clears sticky bits on the next edge according to clrData. Bit 0 clears all three sticky bits, bit 1 clears receive underflow (rawInt bit 2), bit 2 clears receive overflow (rawInt bit 3), and bit 3 clears transmit overflow (rawInt bit 1).
- R9: When a sticky event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R10: maskedInt equals rawInt AND intMask with no added delay. irqOut is high exactly when maskedInt is nonzero.
- R11: While ctrlEnable is low, fifoFlush is high, all three ok strobes are low, and no request sets a sticky bit.
- R12: During reset, statusWord, rawInt, maskedInt and irqOut are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlEnable | input | 1 | Controller enable; low flushes FIFOs |
| engineBusy | input | 1 | Serial engine is shifting a word |
| txLevel | input | LVL_W | Transmit FIFO fill level |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| txPushReq | input | 1 | Software write into transmit FIFO |
| rxPushReq | input | 1 | Engine write into receive FIFO |
| rxPopReq | input | 1 | Software read from receive FIFO |
| txThresh | input | LVL_W | Transmit threshold |
| rxThresh | input | LVL_W | Receive threshold |
| intMask | input | 5 | Interrupt enable mask |
| clrWrite | input | 1 | Clear register write strobe |
| clrData | input | 4 | Clear register write data |
| txPushOk | output | 1 | Transmit push accepted |
| rxPushOk | output | 1 | Receive push accepted |
| rxPopOk | output | 1 | Receive pop accepted |
| fifoFlush | output | 1 | Flush both FIFOs |
| statusWord | output | 5 | Status flags |
| rawInt | output | 5 | Raw interrupt word |
| maskedInt | output | 5 | Masked interrupt word |
| irqOut | output | 1 | Interrupt line |

## Verification
Two functions can land in the same cycle: a sticky error event, and a software clear that names the same bit. The bench provokes this by asserting a transmit push at full level in the same cycle as a clear-all write. After the edge it checks that transmit overflow is set while the other sticky bits are gone. The bench also sweeps every clear value over a fully set sticky word, and every mask over two raw patterns, and checks each result against arithmetic done in the bench.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int STAT_W = 5;
  localparam int INT_W  = 5;
  localparam int CLR_W  = 4;

  // status bit positions
  localparam int ST_BUSY    = 0;
  localparam int ST_TXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_RXEMPTY = 3;
  localparam int ST_RXFULL  = 4;

  // interrupt bit positions
  localparam int IT_TXLOW = 0;
  localparam int IT_TXOVF = 1;
  localparam int IT_RXUNF = 2;
  localparam int IT_RXOVF = 3;
  localparam int IT_RXHIT = 4;

  // clear register bit positions
  localparam int CL_ALL   = 0;
  localparam int CL_RXUNF = 1;
  localparam int CL_RXOVF = 2;
  localparam int CL_TXOVF = 3;

  localparam int STICKY_N = 3;

  typedef struct packed {
    logic txFull;
    logic txEmpty;
    logic rxFull;
    logic rxEmpty;
  } fifoFlags_t;

  // strobes from control to datapath, one set/clear pair per sticky source
  typedef struct packed {
    logic [STICKY_N-1:0] setEv;  // [0]=tx ovf, [1]=rx unf, [2]=rx ovf
    logic [STICKY_N-1:0] clrEv;
  } stickyCmd_t;
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               ctrlEnable,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic               txPushReq,
  input  logic               rxPushReq,
  input  logic               rxPopReq,
  input  logic               clrWrite,
  input  logic [CLR_W-1:0]   clrData,
  output fifoFlags_t         flags,
  output stickyCmd_t         cmd,
  output logic               txPushOk,
  output logic               rxPushOk,
  output logic               rxPopOk,
  output logic               fifoFlush
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic clrAll;

  always_comb begin
    flags.txFull  = (txLevel == FULL_LVL);
    flags.txEmpty = (txLevel == '0);
    flags.rxFull  = (rxLevel == FULL_LVL);
    flags.rxEmpty = (rxLevel == '0);
  end

  // strobe gating: refuse anything that would over- or underflow
  always_comb begin
    fifoFlush = ~ctrlEnable;
    txPushOk  = ctrlEnable & txPushReq & ~flags.txFull;
    rxPushOk  = ctrlEnable & rxPushReq & ~flags.rxFull;
    rxPopOk   = ctrlEnable & rxPopReq  & ~flags.rxEmpty;
  end

  // error events and clear decode
  always_comb begin
    clrAll       = clrWrite & clrData[CL_ALL];
    cmd.setEv[0] = ctrlEnable & txPushReq & flags.txFull;
    cmd.setEv[1] = ctrlEnable & rxPopReq  & flags.rxEmpty;
    cmd.setEv[2] = ctrlEnable & rxPushReq & flags.rxFull;
    cmd.clrEv[0] = clrAll | (clrWrite & clrData[CL_TXOVF]);
    cmd.clrEv[1] = clrAll | (clrWrite & clrData[CL_RXUNF]);
    cmd.clrEv[2] = clrAll | (clrWrite & clrData[CL_RXOVF]);
  end
endmodule

// File: rtl/spi_irq_datapath.sv
module spi_irq_datapath
  import spi_irq_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEnable,
  input  logic              engineBusy,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  txThresh,
  input  logic [LVL_W-1:0]  rxThresh,
  input  logic [INT_W-1:0]  intMask,
  input  fifoFlags_t        flags,
  input  stickyCmd_t        cmd,
  output logic [STAT_W-1:0] statusWord,
  output logic [INT_W-1:0]  rawInt,
  output logic [INT_W-1:0]  maskedInt,
  output logic              irqOut
);
  // map sticky index to interrupt bit position
  localparam int STICKY_POS [STICKY_N] = '{IT_TXOVF, IT_RXUNF, IT_RXOVF};

  logic [STAT_W-1:0]   statusQ;
  logic                txLowQ;
  logic                rxHitQ;
  logic [STICKY_N-1:0] stickyQ;

  // level-derived state, refreshed every edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      txLowQ  <= 1'b0;
      rxHitQ  <= 1'b0;
    end else begin
      statusQ[ST_BUSY]    <= ctrlEnable & (engineBusy | ~flags.txEmpty);
      statusQ[ST_TXFULL]  <= flags.txFull;
      statusQ[ST_TXEMPTY] <= flags.txEmpty;
      statusQ[ST_RXEMPTY] <= flags.rxEmpty;
      statusQ[ST_RXFULL]  <= flags.rxFull;
      txLowQ              <= (txLevel <= txThresh);
      rxHitQ              <= (rxLevel > rxThresh);
    end
  end

  // sticky error bits: a new event wins over a clear in the same cycle
  for (genvar g = 0; g < STICKY_N; g++) begin : gSticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stickyQ[g] <= 1'b0;
      else if (cmd.setEv[g])
        stickyQ[g] <= 1'b1;
      else if (cmd.clrEv[g])
        stickyQ[g] <= 1'b0;
    end
  end

  always_comb begin
    rawInt           = '0;
    rawInt[IT_TXLOW] = txLowQ;
    rawInt[IT_RXHIT] = rxHitQ;
    for (int k = 0; k < STICKY_N; k++)
      rawInt[STICKY_POS[k]] = stickyQ[k];
  end

  assign statusWord = statusQ;
  assign maskedInt  = rawInt & intMask;
  assign irqOut     = |maskedInt;
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEnable,
  input  logic              engineBusy,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              txPushReq,
  input  logic              rxPushReq,
  input  logic              rxPopReq,
  input  logic [LVL_W-1:0]  txThresh,
  input  logic [LVL_W-1:0]  rxThresh,
  input  logic [4:0]        intMask,
  input  logic              clrWrite,
  input  logic [3:0]        clrData,
  output logic              txPushOk,
  output logic              rxPushOk,
  output logic              rxPopOk,
  output logic              fifoFlush,
  output logic [4:0]        statusWord,
  output logic [4:0]        rawInt,
  output logic [4:0]        maskedInt,
  output logic              irqOut
);
  fifoFlags_t flags;
  stickyCmd_t cmd;

  spi_irq_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) uCtrl (
    .ctrlEnable(ctrlEnable), .txLevel(txLevel), .rxLevel(rxLevel),
    .txPushReq(txPushReq), .rxPushReq(rxPushReq), .rxPopReq(rxPopReq),
    .clrWrite(clrWrite), .clrData(clrData), .flags(flags), .cmd(cmd),
    .txPushOk(txPushOk), .rxPushOk(rxPushOk), .rxPopOk(rxPopOk),
    .fifoFlush(fifoFlush)
  );

  spi_irq_datapath #(.LVL_W(LVL_W)) uData (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .engineBusy(engineBusy),
    .txLevel(txLevel), .rxLevel(rxLevel), .txThresh(txThresh),
    .rxThresh(rxThresh), .intMask(intMask), .flags(flags), .cmd(cmd),
    .statusWord(statusWord), .rawInt(rawInt), .maskedInt(maskedInt),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk #(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlEnable,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic             txPushReq,
  input logic             rxPushReq,
  input logic             rxPopReq,
  input logic             clrWrite,
  input logic [3:0]       clrData,
  input logic [4:0]       intMask,
  input logic             txPushOk,
  input logic             rxPushOk,
  input logic             rxPopOk,
  input logic             fifoFlush,
  input logic [4:0]       rawInt,
  input logic             irqOut
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEnable && txPushReq && txLevel == FULL_LVL |=> rawInt[1]); // R5
  AST_TX_FULL_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    txLevel == FULL_LVL |-> !txPushOk); // R5
  AST_TX_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rawInt[1] && !clrWrite |=> rawInt[1]); // R5
  AST_RX_UNF_SET: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEnable && rxPopReq && rxLevel == '0 |=> rawInt[2]); // R6
  AST_RX_UNF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rawInt[2] && !clrWrite |=> rawInt[2]); // R6
  AST_RX_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEnable && rxPushReq && rxLevel == FULL_LVL |=> rawInt[3]); // R7
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    clrWrite && clrData[0] && !(ctrlEnable && txPushReq && txLevel == FULL_LVL)
    |=> !rawInt[1]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rawInt & intMask) == 5'd0 |-> !irqOut); // R10
  AST_FLUSH_GATES: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnable |-> fifoFlush && !txPushOk && !rxPushOk && !rxPopOk); // R11
endmodule

bind spi_irq_status spi_irq_status_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) uChk (
  .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .txLevel(txLevel),
  .rxLevel(rxLevel), .txPushReq(txPushReq), .rxPushReq(rxPushReq),
  .rxPopReq(rxPopReq), .clrWrite(clrWrite), .clrData(clrData),
  .intMask(intMask), .txPushOk(txPushOk), .rxPushOk(rxPushOk),
  .rxPopOk(rxPopOk), .fifoFlush(fifoFlush), .rawInt(rawInt), .irqOut(irqOut)
);

// File: tb/spi_irq_status_test.sv
`timescale 1ns/1ps
module spi_irq_status_test;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlEnable = 1'b0, engineBusy = 1'b0;
  logic [LW-1:0] txLevel = '0, rxLevel = '0, txThresh = '0, rxThresh = '0;
  logic txPushReq = 1'b0, rxPushReq = 1'b0, rxPopReq = 1'b0;
  logic [4:0] intMask = '0;
  logic clrWrite = 1'b0;
  logic [3:0] clrData = '0;
  logic txPushOk, rxPushOk, rxPopOk, fifoFlush, irqOut;
  logic [4:0] statusWord, rawInt, maskedInt;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_irq_status #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .engineBusy(engineBusy),
    .txLevel(txLevel), .rxLevel(rxLevel), .txPushReq(txPushReq),
    .rxPushReq(rxPushReq), .rxPopReq(rxPopReq), .txThresh(txThresh),
    .rxThresh(rxThresh), .intMask(intMask), .clrWrite(clrWrite),
    .clrData(clrData), .txPushOk(txPushOk), .rxPushOk(rxPushOk),
    .rxPopOk(rxPopOk), .fifoFlush(fifoFlush), .statusWord(statusWord),
    .rawInt(rawInt), .maskedInt(maskedInt), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setAllSticky();
    txLevel = LW'(DEPTH); rxLevel = LW'(DEPTH);
    txPushReq = 1'b1; rxPushReq = 1'b1;
    step();
    txPushReq = 1'b0; rxPushReq = 1'b0;
    rxLevel = '0; rxPopReq = 1'b1;
    step();
    rxPopReq = 1'b0;
  endtask

  initial begin
    #1;
    // R12: reset state
    check(statusWord == 5'd0, "R12 status", statusWord, 0);
    check(rawInt == 5'd0 && maskedInt == 5'd0 && !irqOut, "R12 raw", rawInt, 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    ctrlEnable = 1'b1;
    step();

    // R1 R2 R3: transmit level vs threshold sweep
    for (int t = 0; t < DEPTH; t++) begin
      for (int l = 0; l <= DEPTH; l++) begin
        txThresh = LW'(t); txLevel = LW'(l);
        rxLevel = '0; rxThresh = '0;
        step();
        check(rawInt[0] == (l <= t), "R3 txLow", rawInt[0], int'(l <= t));
        check(statusWord[1] == (l == DEPTH) && statusWord[2] == (l == 0),
              "R1 tx flags", statusWord, {(l == 0), (l == DEPTH), 1'b0});
        check(statusWord[0] == (l != 0), "R2 busy tx", statusWord[0], int'(l != 0));
      end
    end

    // R1 R4: receive level vs threshold sweep
    txLevel = LW'(4); txThresh = '0;
    for (int t = 0; t < DEPTH; t++) begin
      for (int l = 0; l <= DEPTH; l++) begin
        rxThresh = LW'(t); rxLevel = LW'(l);
        step();
        check(rawInt[4] == (l > t), "R4 rxHit", rawInt[4], int'(l > t));
        check(statusWord[3] == (l == 0) && statusWord[4] == (l == DEPTH),
              "R1 rx flags", statusWord[4:3], {(l == DEPTH), (l == 0)});
      end
    end

    // R2: busy from engine
    txLevel = '0;
    for (int b = 0; b < 4; b++) begin
      ctrlEnable = b[1]; engineBusy = b[0];
      step();
      check(statusWord[0] == (b == 3), "R2 busy", statusWord[0], int'(b == 3));
    end
    ctrlEnable = 1'b1; engineBusy = 1'b0;

    // levels for sticky tests: rawInt[0] and [4] stay 0
    txThresh = '0; rxThresh = LW'(DEPTH - 1);

    // R5: push below full accepted, at full refused
    txLevel = LW'(3); txPushReq = 1'b1; #1;
    check(txPushOk == 1'b1, "R5 accept", txPushOk, 1);
    step();
    check(rawInt[1] == 1'b0, "R5 no ovf", rawInt[1], 0);
    txLevel = LW'(DEPTH); #1;
    check(txPushOk == 1'b0, "R5 refuse", txPushOk, 0);
    step();
    txPushReq = 1'b0; txLevel = LW'(4);
    check(rawInt[1] == 1'b1, "R5 set", rawInt[1], 1);
    step(); step();
    check(rawInt[1] == 1'b1, "R5 sticky", rawInt[1], 1);

    // R6: pop on empty
    rxLevel = '0; rxPopReq = 1'b1; #1;
    check(rxPopOk == 1'b0, "R6 refuse", rxPopOk, 0);
    step();
    rxPopReq = 1'b0;
    check(rawInt[2] == 1'b1, "R6 set", rawInt[2], 1);

    // R7: receive push at full
    rxLevel = LW'(2); rxPushReq = 1'b1; #1;
    check(rxPushOk == 1'b1, "R7 accept", rxPushOk, 1);
    rxLevel = LW'(DEPTH); #1;
    check(rxPushOk == 1'b0, "R7 refuse", rxPushOk, 0);
    step();
    rxPushReq = 1'b0; rxLevel = '0;
    check(rawInt[3] == 1'b1, "R7 set", rawInt[3], 1);

    // R8: every clear value over a full sticky word
    for (int c = 0; c < 16; c++) begin
      logic [4:0] expRaw;
      setAllSticky();
      txLevel = LW'(4); rxLevel = '0;
      clrWrite = 1'b1; clrData = 4'(c);
      step();
      clrWrite = 1'b0; clrData = '0;
      expRaw = 5'b01110;
      if (c[0]) expRaw = 5'b00000;
      else begin
        if (c[3]) expRaw[1] = 1'b0;
        if (c[1]) expRaw[2] = 1'b0;
        if (c[2]) expRaw[3] = 1'b0;
      end
      check(rawInt == expRaw, "R8 clear", rawInt, expRaw);
    end

    // R9: overflow event and clear-all in the same cycle
    setAllSticky();
    txLevel = LW'(DEPTH); txPushReq = 1'b1;
    clrWrite = 1'b1; clrData = 4'b0001;
    step();
    txPushReq = 1'b0; clrWrite = 1'b0; clrData = '0; txLevel = LW'(4);
    check(rawInt == 5'b00010, "R9 set wins", rawInt, 5'b00010);

    // R10: mask sweep over two raw patterns
    setAllSticky();
    txLevel = '0; txThresh = '0; rxLevel = LW'(DEPTH); rxThresh = '0;
    step();
    for (int p = 0; p < 2; p++) begin
      logic [4:0] pat;
      pat = (p == 0) ? 5'b11111 : 5'b10101;
      if (p == 1) begin
        clrWrite = 1'b1; clrData = 4'b0100; step();
        clrWrite = 1'b1; clrData = 4'b1000; step();
        clrWrite = 1'b0; clrData = '0;
      end
      check(rawInt == pat, "R10 pattern", rawInt, pat);
      for (int m = 0; m < 32; m++) begin
        intMask = 5'(m); #1;
        check(maskedInt == (pat & 5'(m)), "R10 masked", maskedInt, pat & 5'(m));
        check(irqOut == ((pat & 5'(m)) != 0), "R10 irq", irqOut,
              int'((pat & 5'(m)) != 0));
      end
    end
    intMask = '0;

    // R11: disabled controller
    clrWrite = 1'b1; clrData = 4'b0001; step();
    clrWrite = 1'b0; clrData = '0;
    ctrlEnable = 1'b0;
    txLevel = LW'(DEPTH); rxLevel = LW'(DEPTH);
    txPushReq = 1'b1; rxPushReq = 1'b1; #1;
    check(fifoFlush && !txPushOk && !rxPushOk, "R11 gates",
          {fifoFlush, txPushOk, rxPushOk}, 3'b100);
    step();
    txPushReq = 1'b0; rxPushReq = 1'b0; rxLevel = '0; rxPopReq = 1'b1; #1;
    check(!rxPopOk, "R11 pop", rxPopOk, 0);
    step();
    rxPopReq = 1'b0;
    check(rawInt[3:1] == 3'b000, "R11 no events", rawInt[3:1], 0);
    check(statusWord[0] == 1'b0, "R11 busy", statusWord[0], 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule